// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block reads from a raw asynchronous NAND flash part over its parallel interface. A host presents one request: a page (row) address, a page-size code, a row-cycle choice and a read mode (main page, spare area or device ID). The block drives the chip-enable, command-latch, address-latch and write strobe to issue the command and address cycles. For page reads it then waits for the ready/busy line. After that it pulses the read strobe and hands the returned data to the host one byte at a time over a valid/ready interface. Bytes are grouped in 512-byte chunks, and a chunk marker flags the last byte of each chunk.

The command opcode, the number of column cycles and the trailing confirm opcode all follow from the page size. Every strobe lasts a fixed number of clocks, set by a parameter. The ready/busy input is taken to be synchronous to the block clock. The data bus width is a build parameter of 8 or 16 bits. On the wide bus, each read strobe returns two bytes, and the low byte is sent out first.

Top module: `nand_page_reader`

## Requirements
- R1: Out of reset, chip-enable is inactive (high), both latch enables are low, both strobes are high, and rd_valid, done and busy are low.
- R2: A main-page read (mode code 0) issues opcode 0x00, then a zero column, then the row address.
- R3: Page-size codes are 0 for 512 B, 1 for 2048 B and 2 for 4096 B. A large page (2048 B or 4096 B) uses two column cycles and ends with confirm opcode 0x30. A 512 B page uses one column cycle and sends no confirm.
- R4: A spare read (mode code 1) on a large page uses opcode 0x00 with the column equal to the page size, sent low byte first. So 2048 gives 0x00, 0x08 and 4096 gives 0x00, 0x10. On a 512 B page it uses opcode 0x50 with column 0x00.
- R5: The row address is sent low byte first. Bits 7:0 and 15:8 always go out. Bits 23:16 follow only when req_row3 is 1.
- R6: After the last command cycle of a page read, the block polls ready/busy once per clock for up to BUSY_POLLS clocks, waiting for it to go low. It then waits without limit for ready/busy to be high before the first read strobe.
- R7: An ID read (mode code 2) issues opcode 0x90 and one address cycle of 0x00. It does not wait for ready and returns five bytes taken from data lines 7:0.
- R8: A main read returns exactly the page size in bytes. A spare read returns 16, 64 or 128 bytes for page codes 0, 1 and 2.
- R9: On the 16-bit bus, each read strobe yields two output bytes: lines 7:0 first, then lines 15:8.
- R10: rd_chunk_end is high with the 512th byte of each chunk of a main read, and with the last byte of any read.
- R11: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data does not change.
- R12: Each command or address cycle holds exactly one latch enable high for 2*STRB_CLKS clocks, with the write strobe low for the first STRB_CLKS of them. The two latch enables are never high together. Chip-enable stays low for the whole operation.
- R13: done is high for exactly one clock, in the cycle after the last byte is accepted. busy is low in the clock after that.
- R14: A request presented while busy is high is ignored: no further flash cycles follow, and the block returns to idle after the current operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_mode | input | 2 | 0 main page, 1 spare area, 2 ID |
| req_pgsz | input | 2 | 0 512 B, 1 2048 B, 2 4096 B |
| req_row3 | input | 1 | Send a third row-address cycle |
| req_row | input | 24 | Page (row) address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Command/address byte to flash |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | BUS_W | Data from flash |
| nf_rb | input | 1 | Ready (high) / busy (low), synchronous |
| rd_valid | output | 1 | Output byte valid |
| rd_ready | input | 1 | Host accepts the byte |
| rd_data | output | 8 | Output byte |
| rd_chunk_end | output | 1 | Last byte of a 512-byte chunk or of the read |

## Verification
Two events can meet in one clock. First, the host can refuse a byte in the very cycle the block has finished a word and could start the next strobe. Second, a new request can arrive while the command cycles are still running. The bench stalls rd_ready on a fixed rhythm during wide main and spare reads, so refusals land on both halves of a word and on chunk ends. Each stalled cycle is judged by the unchanged byte, and each read by the full byte stream and markers. The bench also injects a second request in the middle of a command phase and judges it by counting the latch cycles on the pins and by a clean return to idle.

// File: rtl/npr_pkg.sv
package npr_pkg;
  localparam int MAX_STEPS = 8;
  localparam int SENT_W    = 13;

  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_SPARE_512  = 8'h50;
  localparam logic [7:0] OP_CONFIRM    = 8'h30;
  localparam logic [7:0] OP_IDENT      = 8'h90;

  typedef enum logic [1:0] {M_MAIN = 2'd0, M_SPARE = 2'd1, M_ID = 2'd2, M_RSVD = 2'd3} mode_e;
  typedef enum logic [1:0] {PG_512 = 2'd0, PG_2K = 2'd1, PG_4K = 2'd2, PG_RSVD = 2'd3} pgsz_e;
  typedef enum logic [2:0] {S_IDLE, S_BUS, S_WAIT, S_RLO, S_ROUT, S_RHI, S_FIN} st_e;
endpackage

// File: rtl/npr_cycle_plan.sv
module npr_cycle_plan
  import npr_pkg::*;
(
  input  mode_e                             mode,
  input  pgsz_e                             pgsz,
  input  logic [23:0]                       row,
  input  logic                              row3,
  output logic [MAX_STEPS-1:0][8:0]         plan,
  output logic [3:0]                        nsteps,
  output logic [SENT_W-1:0]                 nbytes
);
  // plan entry: bit 8 = command (1) or address (0), bits 7:0 = byte
  logic        big;
  logic [15:0] col;
  int          n;

  always_comb begin
    plan = '0;
    n    = 0;
    big  = (pgsz != PG_512);
    col  = '0;
    if (mode == M_ID) begin
      plan[0] = {1'b1, OP_IDENT};
      plan[1] = {1'b0, 8'h00};
      n       = 2;
    end else begin
      if (mode == M_SPARE && big) col = (pgsz == PG_2K) ? 16'd2048 : 16'd4096;
      plan[n[2:0]] = {1'b1, (mode == M_SPARE && !big) ? OP_SPARE_512 : OP_READ};
      n = n + 1;
      plan[n[2:0]] = {1'b0, col[7:0]};
      n = n + 1;
      if (big) begin
        plan[n[2:0]] = {1'b0, col[15:8]};
        n = n + 1;
      end
      plan[n[2:0]] = {1'b0, row[7:0]};
      n = n + 1;
      plan[n[2:0]] = {1'b0, row[15:8]};
      n = n + 1;
      if (row3) begin
        plan[n[2:0]] = {1'b0, row[23:16]};
        n = n + 1;
      end
      if (big) begin
        plan[n[2:0]] = {1'b1, OP_CONFIRM};
        n = n + 1;
      end
    end
    nsteps = 4'(n);
  end

  always_comb begin
    unique case (mode)
      M_ID:    nbytes = SENT_W'(5);
      M_SPARE: nbytes = (pgsz == PG_512) ? SENT_W'(16)  : (pgsz == PG_2K) ? SENT_W'(64)   : SENT_W'(128);
      default: nbytes = (pgsz == PG_512) ? SENT_W'(512) : (pgsz == PG_2K) ? SENT_W'(2048) : SENT_W'(4096);
    endcase
  end
endmodule

// File: rtl/npr_rb_wait.sv
module npr_rb_wait #(
  parameter int POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb,
  output logic ready
);
  localparam int CW = $clog2(POLLS + 1);

  typedef enum logic [1:0] {W_IDLE, W_SEEK, W_HOLD} wst_e;
  wst_e          st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    ready = 1'b0;
    unique case (st_q)
      W_IDLE: if (start) begin
        st_n  = W_SEEK;
        cnt_n = '0;
      end
      W_SEEK: begin
        if (!rb || cnt_q == CW'(POLLS - 1)) st_n = W_HOLD;
        else cnt_n = cnt_q + 1'b1;
      end
      W_HOLD: if (rb) begin
        ready = 1'b1;
        st_n  = W_IDLE;
      end
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  // R6: while ready/busy stays high and polls remain, the search continues
  p_seek_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_SEEK && rb && cnt_q < CW'(POLLS - 1)) |=> (st_q == W_SEEK));
  // R6: a busy flash holds off the ready indication
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_HOLD && !rb) |=> (st_q == W_HOLD));
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import npr_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int STRB_CLKS  = 2,
  parameter int BUSY_POLLS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       req_pgsz,
  input  logic             req_row3,
  input  logic [23:0]      req_row,
  output logic             busy,
  output logic             done,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_out,
  output logic             nf_dq_oe,
  input  logic [BUS_W-1:0] nf_dq_in,
  input  logic             nf_rb,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_chunk_end
);
  localparam int TW   = $clog2(2 * STRB_CLKS);
  localparam bit WIDE = (BUS_W == 16);

  st_e               st_q, st_n;
  logic [2:0]        idx_q, idx_n;
  logic [TW-1:0]     t_q, t_n;
  logic [BUS_W-1:0]  hold_q, hold_n;
  logic              hsel_q, hsel_n;
  logic [SENT_W-1:0] sent_q, sent_n;
  mode_e             mode_q;
  pgsz_e             pg_q;
  logic [23:0]       row_q;
  logic              r3_q;

  logic [MAX_STEPS-1:0][8:0] plan;
  logic [3:0]        nsteps;
  logic [SENT_W-1:0] nbytes;
  logic [8:0]        cur;
  logic              load, step_end, last_step, wait_start, rb_ready, pair_word;

  npr_cycle_plan u_plan (
    .mode(mode_q), .pgsz(pg_q), .row(row_q), .row3(r3_q),
    .plan(plan), .nsteps(nsteps), .nbytes(nbytes)
  );

  npr_rb_wait #(.POLLS(BUSY_POLLS)) u_rbw (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .rb(nf_rb), .ready(rb_ready)
  );

  assign cur        = plan[idx_q];
  assign load       = (st_q == S_IDLE) && req_valid;
  assign step_end   = (st_q == S_BUS) && (t_q == TW'(2 * STRB_CLKS - 1));
  assign last_step  = ({1'b0, idx_q} == nsteps - 4'd1);
  assign wait_start = step_end && last_step && (mode_q != M_ID);
  assign pair_word  = WIDE && (mode_q != M_ID);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    t_n    = t_q;
    hold_n = hold_q;
    hsel_n = hsel_q;
    sent_n = sent_q;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        st_n   = S_BUS;
        idx_n  = '0;
        t_n    = '0;
        sent_n = '0;
      end
      S_BUS: begin
        t_n = t_q + 1'b1;
        if (step_end) begin
          t_n = '0;
          if (last_step) st_n = (mode_q == M_ID) ? S_RLO : S_WAIT;
          else idx_n = idx_q + 1'b1;
        end
      end
      S_WAIT: if (rb_ready) begin
        st_n = S_RLO;
        t_n  = '0;
      end
      S_RLO: begin
        t_n = t_q + 1'b1;
        if (t_q == TW'(STRB_CLKS - 1)) begin
          hold_n = nf_dq_in;
          hsel_n = 1'b0;
          t_n    = '0;
          st_n   = S_ROUT;
        end
      end
      S_ROUT: if (rd_ready) begin
        sent_n = sent_q + 1'b1;
        if (sent_q == nbytes - 1'b1) st_n = S_FIN;
        else if (pair_word && !hsel_q) hsel_n = 1'b1;
        else begin
          t_n  = '0;
          st_n = S_RHI;
        end
      end
      S_RHI: begin
        t_n = t_q + 1'b1;
        if (t_q == TW'(STRB_CLKS - 1)) begin
          t_n  = '0;
          st_n = S_RLO;
        end
      end
      S_FIN:   st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      t_q    <= '0;
      hold_q <= '0;
      hsel_q <= 1'b0;
      sent_q <= '0;
      mode_q <= M_MAIN;
      pg_q   <= PG_512;
      row_q  <= '0;
      r3_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      t_q    <= t_n;
      hold_q <= hold_n;
      hsel_q <= hsel_n;
      sent_q <= sent_n;
      if (load) begin
        mode_q <= mode_e'(req_mode);
        pg_q   <= pgsz_e'(req_pgsz);
        row_q  <= req_row;
        r3_q   <= req_row3;
      end
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);
  assign nf_ce_n   = (st_q == S_IDLE);
  assign nf_cle    = (st_q == S_BUS) && cur[8];
  assign nf_ale    = (st_q == S_BUS) && !cur[8];
  assign nf_we_n   = !((st_q == S_BUS) && (t_q < TW'(STRB_CLKS)));
  assign nf_dq_out = cur[7:0];
  assign nf_dq_oe  = (st_q == S_BUS);
  assign nf_re_n   = (st_q != S_RLO);
  assign rd_valid  = (st_q == S_ROUT);
  assign rd_chunk_end = rd_valid && ((sent_q[8:0] == 9'h1FF) || (sent_q == nbytes - 1'b1));

  generate
    if (WIDE) begin : g_wide
      assign rd_data = (hsel_q && mode_q != M_ID) ? hold_q[15:8] : hold_q[7:0];
    end else begin : g_narrow
      assign rd_data = hold_q[7:0];
    end
  endgenerate

  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  p_no_read_in_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cle || nf_ale) |-> nf_re_n);
  p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_ignore_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(row_q) && $stable(mode_q) && $stable(pg_q)));
endmodule

// File: tb/nand_page_reader_bench.sv
`timescale 1ns/1ps
module nand_page_reader_bench;
  localparam int BUS_W = 16;
  localparam int STRB  = 2;
  localparam int POLLS = 1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_row3, nf_rb, rd_ready;
  logic [1:0] req_mode, req_pgsz;
  logic [23:0] req_row;
  logic busy, done, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_out, rd_data;
  logic [BUS_W-1:0] nf_dq_in;
  logic rd_valid, rd_chunk_end;

  nand_page_reader #(.BUS_W(BUS_W), .STRB_CLKS(STRB), .BUSY_POLLS(POLLS)) u_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_pgsz(req_pgsz), .req_row3(req_row3), .req_row(req_row),
    .busy(busy), .done(done), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_chunk_end(rd_chunk_end)
  );

  int errs = 0, checks = 0, cyc = 0;

  function automatic logic [7:0] pat(int j);
    return 8'(j * 37 + (j >> 8) * 11 + 5);
  endfunction

  // flash model: data pointer advances on each read-strobe release
  int rd_ptr = 0;
  bit id_mode = 0;
  assign nf_dq_in = id_mode ? {8'hEE, pat(rd_ptr)} : {pat(2 * rd_ptr + 1), pat(2 * rd_ptr)};

  logic [9:0] cmd_q[$];
  logic [7:0] got_q[$];
  bit         ce_q[$];
  int we_run, lat_total, bad_tim, bad_ce, bad_bp;
  int t_cmd, first_re, t_rel, done_cnt, done_cyc, acc_cyc;
  bit stall = 0, pv = 0, pr = 0, prev_we = 1, prev_re = 1, prev_rb = 1, nr;
  logic [7:0] pd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
    if (rst_n) begin
      if (!nf_we_n) we_run++;
      if (nf_cle || nf_ale) lat_total++;
      if (!nf_we_n && !(nf_cle ^ nf_ale)) bad_tim++;
      if (!prev_we && nf_we_n) begin
        cmd_q.push_back({nf_cle, nf_ale, nf_dq_out});
        if (we_run != STRB) bad_tim++;
        we_run = 0;
        t_cmd  = cyc;
        rd_ptr = 0;
      end
      if (!prev_re && nf_re_n) rd_ptr++;
      if (prev_re && !nf_re_n && first_re < 0) first_re = cyc;
      if (!prev_rb && nf_rb) t_rel = cyc;
      if (busy && nf_ce_n) bad_ce++;
      nr = stall ? ((cyc % 3) != 1) : 1'b1;
      if (pv && !pr && (!rd_valid || rd_data != pd)) bad_bp++;
      if (rd_valid && nr) begin
        got_q.push_back(rd_data);
        ce_q.push_back(rd_chunk_end);
        acc_cyc = cyc;
      end
      pv = rd_valid; pr = nr; pd = rd_data;
      rd_ready = nr;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
    prev_we = nf_we_n; prev_re = nf_re_n; prev_rb = nf_rb;
  end

  task automatic run_op(input string tag, input logic [1:0] m, input logic [1:0] pg,
                        input logic [23:0] row, input bit r3, input bit st,
                        input int blen, input bit inject);
    logic [9:0] exp_q[$];
    logic [15:0] col;
    bit big;
    int nb, mis, cmis, nbefore;
    big = (pg != 2'd0);
    if (m == 2'd2) begin
      exp_q.push_back({2'b10, 8'h90});
      exp_q.push_back({2'b01, 8'h00});
      nb = 5;
    end else begin
      exp_q.push_back({2'b10, (m == 2'd1 && !big) ? 8'h50 : 8'h00});
      col = (m == 2'd1 && big) ? ((pg == 2'd2) ? 16'd4096 : 16'd2048) : 16'd0;
      exp_q.push_back({2'b01, col[7:0]});
      if (big) exp_q.push_back({2'b01, col[15:8]});
      exp_q.push_back({2'b01, row[7:0]});
      exp_q.push_back({2'b01, row[15:8]});
      if (r3) exp_q.push_back({2'b01, row[23:16]});
      if (big) exp_q.push_back({2'b10, 8'h30});
      if (m == 2'd1) nb = (pg == 2'd0) ? 16 : (pg == 2'd1) ? 64 : 128;
      else           nb = (pg == 2'd0) ? 512 : (pg == 2'd1) ? 2048 : 4096;
    end
    @(negedge clk);
    cmd_q.delete(); got_q.delete(); ce_q.delete();
    we_run = 0; lat_total = 0; bad_tim = 0; bad_ce = 0; bad_bp = 0;
    first_re = -1; t_rel = -1; done_cnt = 0; t_cmd = 0;
    stall = st; id_mode = (m == 2'd2);
    req_mode = m; req_pgsz = pg; req_row = row; req_row3 = r3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (4) @(negedge clk);
      req_mode = 2'd2; req_row = 24'hFFFFFF; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (cmd_q.size() < exp_q.size()) @(negedge clk);
    if (m != 2'd2 && blen > 0) begin
      repeat (3) @(negedge clk);
      nf_rb = 1'b0;
      repeat (blen) @(negedge clk);
      nf_rb = 1'b1;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);

    mis = (cmd_q.size() != exp_q.size()) ? 1 : 0;
    for (int i = 0; i < exp_q.size() && i < cmd_q.size(); i++)
      if (cmd_q[i] != exp_q[i]) mis++;
    chk(mis == 0, {tag, " command/address cycles"}, mis, 0);
    chk(got_q.size() == nb, "R8 byte count", got_q.size(), nb);
    mis = 0; cmis = 0;
    for (int j = 0; j < got_q.size(); j++) begin
      if (got_q[j] != pat(j)) mis++;
      if (ce_q[j] != ((m == 2'd0 && (j % 512) == 511) || j == nb - 1)) cmis++;
    end
    chk(mis == 0, (m == 2'd2) ? "R7 ID bytes from low lines" : "R9 byte order", mis, 0);
    chk(cmis == 0, "R10 chunk marker", cmis, 0);
    chk(bad_tim == 0 && lat_total == 2 * STRB * exp_q.size() && bad_ce == 0,
        "R12 strobe and latch timing", lat_total, 2 * STRB * exp_q.size());
    if (st) chk(bad_bp == 0, "R11 byte held under stall", bad_bp, 0);
    if (m == 2'd2)
      chk(first_re - t_cmd <= 4 * STRB + 4, "R7 no ready wait", first_re - t_cmd, 4 * STRB + 4);
    else if (blen > 0)
      chk(t_rel > 0 && first_re > t_rel, "R6 read after ready returns", first_re, t_rel + 1);
    else
      chk(first_re - t_cmd >= POLLS && first_re - t_cmd <= POLLS + 4 * STRB + 8,
          "R6 busy-search timeout", first_re - t_cmd, POLLS);
    chk(done_cnt == 1 && done_cyc == acc_cyc + 1 && !busy, "R13 done pulse",
        done_cyc - acc_cyc, 1);
    if (inject) begin
      nbefore = cmd_q.size();
      repeat (30) @(negedge clk);
      chk(cmd_q.size() == nbefore && !busy && nf_ce_n, "R14 request ignored while busy",
          cmd_q.size(), nbefore);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_pgsz = '0; req_row = '0;
    req_row3 = 1'b0; nf_rb = 1'b1; rd_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nf_ce_n && !nf_cle && !nf_ale && nf_we_n && nf_re_n && !rd_valid && !done && !busy,
        "R1 reset state", {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, rd_valid, done, busy},
        8'b1001_1000);
    run_op("R7",       2'd2, 2'd0, 24'h000000, 1'b0, 1'b0, 0,  1'b0);
    run_op("R2 R3 R5", 2'd0, 2'd0, 24'h00A5C3, 1'b0, 1'b0, 20, 1'b0);
    run_op("R2 R3 R5", 2'd0, 2'd1, 24'h123456, 1'b1, 1'b1, 40, 1'b0);
    run_op("R4 R3",    2'd1, 2'd1, 24'h000777, 1'b0, 1'b0, 10, 1'b0);
    run_op("R4 R5",    2'd1, 2'd0, 24'h0ABCDE, 1'b1, 1'b1, 5,  1'b0);
    run_op("R2 R3",    2'd0, 2'd2, 24'h3C0F81, 1'b1, 1'b0, 0,  1'b0);
    run_op("R4 R14",   2'd1, 2'd2, 24'h00F00D, 1'b0, 1'b1, 15, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule